// File: doc/BRIEF.md
# Prioritised Two-Output Interrupt Controller

This block gathers up to 32 request lines and presents them to a processor on two outputs: a normal interrupt and a fast interrupt. Each line has its own configuration word. The word sets a priority from 0 to 31, where 0 is the most urgent. It also sets whether the line is edge-sensitive or level-sensitive, and which of the two outputs the line is routed to. Requests are latched as pending bits, and a mask register then decides which pending lines may take part in the contest for an output.

Each output has an armed flag. An output asserts only when it is armed and at least one pending, unmasked line is routed to it. At that moment the flag clears and the winning line number is latched. Software reads the latched number and services the line, then writes the control register to drop the output and arm it again. Reading the source number acknowledges the line: the pending bit is cleared for edge-sensitive lines only. A software-set register lets firmware inject a request on one line. All registers are 32-bit words on a single-cycle bus with a valid strobe and a write flag. Reads are combinational in the same cycle, and every side effect takes place at the following clock edge.

Top module: `vec_intc`

## Requirements
- R1: After reset, all pending bits, sensitivities, routes and priorities are 0, the mask (offset 0x04) reads 0xFFFFFFFF, both source numbers read 0, and both outputs are low.
- R2: The configuration word for line n is at offset 0x1C + 4n. Bits [6:2] hold the priority, bit 1 the sensitivity (1 = level, 0 = edge) and bit 0 the route (1 = fast output, 0 = normal output). A read returns the same layout, with all higher bits 0.
- R3: For an edge line, the pending bit (read at 0x00) is set only when the input is high in a cycle where it was low in the previous cycle. An input held high does not set the bit again after it is cleared.
- R4: For a level line, the pending bit is set in every cycle the input is high, and it is cleared in the cycle the input falls.
- R5: A write to 0x00 ANDs the pending bits with the write data. A level line whose input is currently high stays pending whatever the data.
- R6: A masked line (mask bit 1) never drives an output. A write to the mask register is taken into account by both outputs in the same cycle.
- R7: The route bit selects which output a line drives. The fast source number is read at 0x14 and the normal one at 0x10.
- R8: Among the candidates for an output, the lowest priority value wins. Equal priorities go to the higher line number.
- R9: An output asserts only while it is armed. On assertion it latches the winner and disarms. It then stays high, and its source number does not change, until it is re-armed.
- R10: Writing bit 0 of the control register (0x18) drops the normal output and re-arms it; bit 1 does the same for the fast output. Re-evaluation takes place in the same cycle, so a waiting candidate keeps the output high and becomes the new source number.
- R11: Reading a source-number register returns the latched line number. If that line is edge-sensitive its pending bit is cleared; a level line's pending bit is left as it is.
- R12: Writing the software-set register (0x9C) makes only the lowest-numbered set data bit pending.
- R13: The control register, the software-set register and unmapped offsets read 0. Writes to the source-number registers have no effect.
- R14: The outputs are registered: they change at the first clock edge after the causing input or bus event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_LINES | Request lines, synchronous to clk |
| bus_valid_i | input | 1 | Access strobe for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during the read cycle |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench builds the block with its default parameters: 32 lines and 5-bit priorities. This puts line 0, line 31, priority 0 and priority 31 all within reach of the arbitration table. As a result, the tie rule and the extreme priority values are exercised at the ends of the line range, not only in the middle. With these defaults the full register map is populated, so the last configuration word is reachable. So is the software-set word directly after it, which must not be decoded as a configuration word.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam logic [7:0] OFS_PEND    = 8'h00;
  localparam logic [7:0] OFS_MASK    = 8'h04;
  localparam logic [7:0] OFS_SRC_IRQ = 8'h10;
  localparam logic [7:0] OFS_SRC_FIQ = 8'h14;
  localparam logic [7:0] OFS_CTRL    = 8'h18;
  localparam logic [7:0] OFS_CFG0    = 8'h1C;
  localparam logic [7:0] OFS_SWSET   = 8'h9C;

  localparam int CFG_ROUTE_BIT = 0;
  localparam int CFG_SENSE_BIT = 1;
  localparam int CFG_PRIO_LSB  = 2;

  localparam int OUT_IRQ = 0;
  localparam int OUT_FIQ = 1;
  localparam int NOUT    = 2;

  // isolates the lowest set bit of a word
  function automatic logic [31:0] lowest_set(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  // assembles a configuration word from its fields
  function automatic logic [31:0] cfg_word(input logic [31:0] prio,
                                           input logic sense,
                                           input logic route);
    logic [31:0] w;
    w = prio << CFG_PRIO_LSB;
    w[CFG_SENSE_BIT] = sense;
    w[CFG_ROUTE_BIT] = route;
    return w;
  endfunction
endpackage

// File: rtl/vec_intc_pending.sv
module vec_intc_pending #(
  parameter int N = 32
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] level_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] sw_set_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_d
);
  logic [N-1:0] in_q;
  logic [N-1:0] rise, fall, set_v, clr_v;

  always_comb begin
    rise  = req_i & ~in_q;
    fall  = ~req_i & in_q;
    set_v = (rise & ~level_i) | (req_i & level_i) | sw_set_i;
    clr_v = (fall & level_i) | ack_clr_i;
    if (wr_i) clr_v = clr_v | (~wdata_i & ~(level_i & req_i));
    pend_d = (pend_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= '0;
      pend_q <= '0;
    end else begin
      in_q   <= req_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/vec_intc_arbiter.sv
module vec_intc_arbiter #(
  parameter int N     = 32,
  parameter int PW    = 5,
  parameter int IDX_W = 5
)(
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            any_o,
  output logic [IDX_W-1:0] win_o
);
  logic [PW-1:0] best;

  // scan upward; "<=" hands ties to the higher line number
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (prio_i[i*PW +: PW] <= best)) begin
        any_o = 1'b1;
        best  = prio_i[i*PW +: PW];
        win_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intc_outctl.sv
module vec_intc_outctl #(
  parameter int IDX_W = 5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             rearm_i,
  output logic             out_o,
  output logic             armed_o,
  output logic [IDX_W-1:0] src_o
);
  logic arm_eff;
  assign arm_eff = armed_o | rearm_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_o   <= 1'b0;
      armed_o <= 1'b1;
      src_o   <= '0;
    end else if (arm_eff && any_i) begin
      out_o   <= 1'b1;
      armed_o <= 1'b0;
      src_o   <= win_i;
    end else if (rearm_i) begin
      out_o   <= 1'b0;
      armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  // bus decode
  logic bus_rd, bus_wr;
  logic [5:0] cfg_word_idx;
  logic cfg_hit;
  logic [IDX_W-1:0] cfg_idx;
  logic wr_pend, wr_mask, wr_ctrl, wr_cfg, wr_swset;
  logic [NOUT-1:0] rd_src;

  assign bus_rd = bus_valid_i & ~bus_write_i;
  assign bus_wr = bus_valid_i & bus_write_i;
  assign cfg_word_idx = bus_addr_i[7:2] - OFS_CFG0[7:2];
  assign cfg_hit  = (bus_addr_i >= OFS_CFG0) && (bus_addr_i[1:0] == 2'b00)
                    && (int'(cfg_word_idx) < NUM_LINES);
  assign cfg_idx  = cfg_word_idx[IDX_W-1:0];
  assign wr_pend  = bus_wr && (bus_addr_i == OFS_PEND);
  assign wr_mask  = bus_wr && (bus_addr_i == OFS_MASK);
  assign wr_ctrl  = bus_wr && (bus_addr_i == OFS_CTRL);
  assign wr_swset = bus_wr && (bus_addr_i == OFS_SWSET);
  assign wr_cfg   = bus_wr && cfg_hit;
  assign rd_src[OUT_IRQ] = bus_rd && (bus_addr_i == OFS_SRC_IRQ);
  assign rd_src[OUT_FIQ] = bus_rd && (bus_addr_i == OFS_SRC_FIQ);

  // configuration state
  logic [NUM_LINES-1:0] mask_q, mask_d, level_q, level_d, route_q, route_d;
  logic [PRIO_W-1:0]    prio_q [NUM_LINES];
  logic [PRIO_W-1:0]    prio_d [NUM_LINES];
  logic [NUM_LINES*PRIO_W-1:0] prio_flat_d;

  always_comb begin
    mask_d  = mask_q;
    level_d = level_q;
    route_d = route_q;
    prio_d  = prio_q;
    if (wr_mask) mask_d = bus_wdata_i[NUM_LINES-1:0];
    if (wr_cfg) begin
      prio_d[cfg_idx]  = bus_wdata_i[CFG_PRIO_LSB +: PRIO_W];
      level_d[cfg_idx] = bus_wdata_i[CFG_SENSE_BIT];
      route_d[cfg_idx] = bus_wdata_i[CFG_ROUTE_BIT];
    end
    for (int i = 0; i < NUM_LINES; i++) prio_flat_d[i*PRIO_W +: PRIO_W] = prio_d[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      level_q <= '0;
      route_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else begin
      mask_q  <= mask_d;
      level_q <= level_d;
      route_q <= route_d;
      prio_q  <= prio_d;
    end
  end

  // per-output handshake state
  logic [NOUT-1:0]  out_q, armed_q, rearm;
  logic [IDX_W-1:0] src_q [NOUT];
  assign rearm = wr_ctrl ? bus_wdata_i[NOUT-1:0] : '0;

  // acknowledge and software set
  logic [NUM_LINES-1:0] ack_vec, ack_clr, sw_set, pend_q, pend_d;
  logic [31:0] sw_low;
  assign sw_low = lowest_set(bus_wdata_i);
  assign sw_set = wr_swset ? sw_low[NUM_LINES-1:0] : '0;

  always_comb begin
    ack_vec = '0;
    for (int k = 0; k < NOUT; k++)
      if (rd_src[k]) ack_vec = ack_vec | (NUM_LINES'(1) << src_q[k]);
    ack_clr = ack_vec & ~level_q;
  end

  vec_intc_pending #(.N(NUM_LINES)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .level_i   (level_q),
    .wr_i      (wr_pend),
    .wdata_i   (bus_wdata_i[NUM_LINES-1:0]),
    .sw_set_i  (sw_set),
    .ack_clr_i (ack_clr),
    .pend_q    (pend_q),
    .pend_d    (pend_d)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [NUM_LINES-1:0] cand;
    logic                 any;
    logic [IDX_W-1:0]     win;
    assign cand = pend_d & ~mask_d & ((k == OUT_FIQ) ? route_d : ~route_d);

    vec_intc_arbiter #(.N(NUM_LINES), .PW(PRIO_W), .IDX_W(IDX_W)) u_arb (
      .cand_i (cand),
      .prio_i (prio_flat_d),
      .any_o  (any),
      .win_o  (win)
    );

    vec_intc_outctl #(.IDX_W(IDX_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_i   (any),
      .win_i   (win),
      .rearm_i (rearm[k]),
      .out_o   (out_q[k]),
      .armed_o (armed_q[k]),
      .src_o   (src_q[k])
    );
  end

  assign irq_o = out_q[OUT_IRQ];
  assign fiq_o = out_q[OUT_FIQ];

  // named events for the checker
  logic irq_armed, fiq_armed, rearm_irq, rearm_fiq;
  assign irq_armed = armed_q[OUT_IRQ];
  assign fiq_armed = armed_q[OUT_FIQ];
  assign rearm_irq = rearm[OUT_IRQ];
  assign rearm_fiq = rearm[OUT_FIQ];

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd) begin
      if (cfg_hit) begin
        bus_rdata_o = cfg_word(32'(prio_q[cfg_idx]), level_q[cfg_idx], route_q[cfg_idx]);
      end else begin
        case (bus_addr_i)
          OFS_PEND:    bus_rdata_o = 32'(pend_q);
          OFS_MASK:    bus_rdata_o = 32'(mask_q);
          OFS_SRC_IRQ: bus_rdata_o = 32'(src_q[OUT_IRQ]);
          OFS_SRC_FIQ: bus_rdata_o = 32'(src_q[OUT_FIQ]);
          default:     bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/vec_intc_checker.sv
module vec_intc_checker #(
  parameter int N = 32
)(
  input logic         clk,
  input logic         rst_n,
  input logic         irq_o,
  input logic         fiq_o,
  input logic         irq_armed,
  input logic         fiq_armed,
  input logic         rearm_irq,
  input logic         rearm_fiq,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] route_q,
  input logic [N-1:0] level_q,
  input logic [N-1:0] req_i,
  input logic         wr_pend,
  input logic [N-1:0] sw_set
);
  a_r9_disarm_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !irq_armed);

  a_r9_armed_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(irq_armed) || $past(rearm_irq)));

  a_r9_hold_until_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rearm_irq) |=> irq_o);

  a_r10_rearm_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_fiq |=> (fiq_o || fiq_armed));

  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (|(pend_q & ~mask_q & ~route_q)));

  a_r7_fiq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> (|(pend_q & ~mask_q & route_q)));

  a_r5_level_survives_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(level_q & req_i)) == $past(level_q & req_i)));

  a_r12_single_inject: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_set));
endmodule

bind vec_intc vec_intc_checker #(.N(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_armed (irq_armed),
  .fiq_armed (fiq_armed),
  .rearm_irq (rearm_irq),
  .rearm_fiq (rearm_fiq),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .route_q   (route_q),
  .level_q   (level_q),
  .req_i     (req_i),
  .wr_pend   (wr_pend),
  .sw_set    (sw_set)
);

// File: tb/sim_vec_intc.sv
`timescale 1ns/1ps
module sim_vec_intc;
  localparam int N = 32;
  localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_SIRQ = 8'h10,
                         A_SFIQ = 8'h14, A_CTRL = 8'h18, A_SWS = 8'h9C;

  // arbitration table: {line a, prio a, line b, prio b, expected winner}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {5'd3,  5'd4,  5'd7,  5'd4,  5'd7},
    {5'd3,  5'd2,  5'd7,  5'd4,  5'd3},
    {5'd0,  5'd31, 5'd31, 5'd31, 5'd31},
    {5'd31, 5'd0,  5'd0,  5'd1,  5'd31},
    {5'd5,  5'd10, 5'd6,  5'd9,  5'd6},
    {5'd12, 5'd1,  5'd2,  5'd1,  5'd12},
    {5'd0,  5'd0,  5'd1,  5'd0,  5'd1},
    {5'd20, 5'd7,  5'd21, 5'd8,  5'd20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic valid = 1'b0, write = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_valid_i(valid),
    .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [7:0] cfg_a(input int line);
    return 8'(8'h1C + 4 * line);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; write = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk); valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); valid = 1'b0;
    chk(tag, d, exp);
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk); req = v;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    rchk("R1 pend", A_PEND, 0);
    rchk("R1 mask", A_MASK, 32'hFFFF_FFFF);
    rchk("R1 src irq", A_SIRQ, 0);
    rchk("R1 src fiq", A_SFIQ, 0);
    rchk("R1 cfg", cfg_a(5), 0);

    // R2 config layout
    wr(cfg_a(9), 32'h5F);
    rchk("R2 readback", cfg_a(9), 32'h5F);
    wr(cfg_a(9), 32'hFFFF_FFFF);
    rchk("R2 upper bits", cfg_a(9), 32'h7F);
    wr(cfg_a(9), 0);

    // R8 arbitration table walk, with R11 edge acknowledge
    for (int v = 0; v < NV; v++) begin
      int la, pa, lb, pb, w, lose;
      la = int'(VEC[v][24:20]); pa = int'(VEC[v][19:15]);
      lb = int'(VEC[v][14:10]); pb = int'(VEC[v][9:5]); w = int'(VEC[v][4:0]);
      lose = (w == la) ? lb : la;
      wr(cfg_a(la), 32'(pa) << 2);
      wr(cfg_a(lb), 32'(pb) << 2);
      wr(A_MASK, 0);
      drive((N'(1) << la) | (N'(1) << lb));
      chk("R8 irq up", 32'(irq), 1);
      drive('0);
      rchk("R8 winner", A_SIRQ, 32'(w));
      rchk("R11 loser kept", A_PEND, 32'(1) << lose);
      wr(A_PEND, 0);
      wr(A_CTRL, 1);
      chk("R10 irq down", 32'(irq), 0);
      wr(A_MASK, 32'hFFFF_FFFF);
      wr(cfg_a(la), 0);
      wr(cfg_a(lb), 0);
    end

    // R14 one-cycle output latency
    wr(A_MASK, ~32'h44);
    @(negedge clk); req = 32'h4;
    #1 chk("R14 before edge", 32'(irq), 0);
    @(posedge clk); #1 chk("R14 after edge", 32'(irq), 1);
    drive('0);

    // R9 handshake holds source
    drive(32'h40);
    chk("R9 still high", 32'(irq), 1);
    rchk("R9 src held", A_SIRQ, 2);
    rchk("R11 edge acked", A_PEND, 32'h40);
    // R10 re-arm with waiting candidate
    wr(A_CTRL, 1);
    chk("R10 stays high", 32'(irq), 1);
    rchk("R10 new src", A_SIRQ, 6);
    rchk("R10 pend clear", A_PEND, 0);
    wr(A_CTRL, 1);
    chk("R10 drop", 32'(irq), 0);
    drive('0);

    // R6 masking and mask-write re-evaluation
    wr(A_MASK, 32'hFFFF_FFFF);
    drive(32'h40);
    chk("R6 masked quiet", 32'(irq), 0);
    wr(A_MASK, ~32'h40);
    chk("R6 unmask fires", 32'(irq), 1);
    rchk("R6 src", A_SIRQ, 6);
    wr(A_PEND, 0);
    wr(A_CTRL, 1);
    drive('0);
    wr(A_MASK, 32'hFFFF_FFFF);

    // R3 edge detection
    drive(32'h10);
    rchk("R3 set", A_PEND, 32'h10);
    wr(A_PEND, 0);
    rchk("R3 no reset while high", A_PEND, 0);
    drive('0);
    drive(32'h10);
    rchk("R3 new edge", A_PEND, 32'h10);
    wr(A_PEND, 0);
    drive('0);

    // R4 / R5 level lines
    wr(cfg_a(8), 32'h2);
    drive(32'h100);
    rchk("R4 level set", A_PEND, 32'h100);
    wr(A_PEND, 0);
    rchk("R5 level kept", A_PEND, 32'h100);
    drive('0);
    rchk("R4 level fall", A_PEND, 0);

    // R5 AND semantics
    drive(32'hA);
    drive('0);
    rchk("R5 both", A_PEND, 32'hA);
    wr(A_PEND, 32'h8);
    rchk("R5 and", A_PEND, 32'h8);
    wr(A_PEND, 0);

    // R7 fast route
    wr(cfg_a(10), 32'h1);
    wr(A_MASK, ~32'h400);
    drive(32'h400);
    chk("R7 fiq up", 32'(fiq), 1);
    chk("R7 irq quiet", 32'(irq), 0);
    rchk("R7 fiq src", A_SFIQ, 10);
    rchk("R11 fiq ack", A_PEND, 0);
    wr(A_CTRL, 2);
    chk("R10 fiq drop", 32'(fiq), 0);
    drive('0);

    // R11 level source not cleared by acknowledge
    wr(A_MASK, ~32'h100);
    drive(32'h100);
    chk("R11 irq up", 32'(irq), 1);
    rchk("R11 level src", A_SIRQ, 8);
    rchk("R11 level kept", A_PEND, 32'h100);
    drive('0);
    wr(A_CTRL, 1);
    chk("R11 irq down", 32'(irq), 0);
    wr(A_MASK, 32'hFFFF_FFFF);

    // R12 software set
    wr(A_SWS, 32'hA0);
    rchk("R12 lowest only", A_PEND, 32'h20);
    wr(A_PEND, 0);

    // R13 read-zero and ignored writes
    rchk("R13 swset reads 0", A_SWS, 0);
    rchk("R13 ctrl reads 0", A_CTRL, 0);
    rchk("R13 unmapped", 8'hA0, 0);
    wr(A_SIRQ, 32'h1F);
    rchk("R13 src write ignored", A_SIRQ, 8);

    summary();
  end
endmodule